// File: doc/BRIEF.md
# Symmetric-Coefficient Bit-Serial Distributed-Arithmetic FIR Filter

This block is a 16-tap FIR filter for coefficient sets that are mirror images of themselves: the tap at position k and the tap at position 15-k have the same weight. Only the eight distinct weights are supplied, as a build-time parameter. It uses distributed arithmetic. The two samples that share a weight are added one bit per clock by a small serial adder. That adder keeps its carry in a flip-flop between clocks. The resulting sum bits address two 16-entry partial-sum tables, each covering four of the eight weights. A two-input adder combines the table outputs, and a right-shifting accumulator weights them.

Each pair sum is one bit wider than a sample, so one output takes nine serial steps. On the ninth step the samples are sign-extended and the weighted term is subtracted rather than added, because that bit is the two's-complement sign of the pair sum. A new sample is offered with a one-cycle valid strobe. It is accepted only while the filter is idle. The full-precision result appears with its own one-cycle strobe and holds until the next result.

Top module: `symDaFir`

## Requirements
- R1: After reset, resultValid is 0, result is 0, and all 16 history positions hold zero. The first output after reset therefore depends only on the samples accepted since reset.
- R2: Each output equals the sum over k=0..15 of c[min(k,15-k)] times x[n-k]. Here x[n] is the newest accepted sample and x[n-k] the one accepted k samples earlier. Samples and weights are 8-bit two's complement. The result is exact, as a 21-bit two's-complement value.
- R3: Weight c[j] sits in bits [8j+7:8j] of the COEFS parameter and serves both tap j and tap 15-j. An impulse (1 followed by zeros) therefore gives the response c0..c7 followed by c7..c0.
- R4: resultValid is a one-cycle pulse. It goes high exactly 9 clock edges after the edge that accepted the sample.
- R5: sampleValid is ignored at the 9 clock edges that follow an accepting edge: no sample enters the history then.
- R6: result keeps its value in every cycle that is not a result cycle.
- R7: Full-scale inputs (-128 and 127) combined with full-scale weights (-128 and 127) give exact results, including the correct sign from the subtracting final step.
- R8: The serial pre-adder carries are cleared when each computation starts. A carry left over from one output never changes the next one.
- R9: A sample offered in the cycle where resultValid is high is accepted at the next edge. The fastest sustained rate is therefore one sample per 10 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| sampleValid | input | 1 | New sample offered this cycle |
| sampleIn | input | 8 | Two's-complement input sample |
| result | output | 21 | Two's-complement filter output |
| resultValid | output | 1 | One-cycle strobe marking a new result |

## Verification
A reference model in the bench convolves the history it has accepted itself with the mirrored weight set. It is checked against the outputs on every clock.

- Impulse test. An impulse shows whether the weights reach the correct mirrored taps. A pairing error would make the response asymmetric.
- Full-scale test. Sequences of full-scale samples test the sign step. If the final step added instead of subtracting, the sign of large results would flip and their magnitude would be wrong.
- Carry test. Alternating extremes would expose a carry left over from the previous computation, which would offset results by a weight.
- Busy test. Holding sampleValid high throughout checks that samples offered while busy are dropped. A design that accepted them would shift the history out of step with the model.

// File: rtl/symDaPkg.sv
package symDaPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic start;  // load new sample, clear carries and accumulator
    logic step;   // process one bit position
    logic msb;    // this step is the sign position of the pair sums
  } daStrobes_t;

endpackage

// File: rtl/symDaTable.sv
// One partial-sum table: entry a holds the sum of the weights whose
// address bit is set in a. Contents are derived from the parameter.
module symDaTable #(
  parameter int CW    = 8,
  parameter int TABIN = 4,
  parameter logic [TABIN*CW-1:0] WEIGHTS = '0,
  localparam int TW    = CW + $clog2(TABIN),
  localparam int DEPTH = 1 << TABIN
) (
  input  logic [TABIN-1:0]    addr,
  output logic signed [TW-1:0] value
);

  function automatic int entrySum(input int a);
    int s;
    s = 0;
    for (int i = 0; i < TABIN; i++) begin
      if (((a >> i) & 1) == 1)
        s += int'($signed(WEIGHTS[i*CW +: CW]));
    end
    return s;
  endfunction

  logic signed [TW-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    localparam int ENTRY = entrySum(a);
    assign rom[a] = TW'(ENTRY);
  end

  assign value = rom[addr];

endmodule

// File: rtl/symDaCtrl.sv
// Sequencer: accepts a sample when idle and then walks the bit positions.
module symDaCtrl import symDaPkg::*; #(
  parameter int DW = 8,
  localparam int PW   = DW + 1,
  localparam int CNTW = $clog2(PW)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleValid,
  output daStrobes_t      str,
  output logic [CNTW-1:0] bitIdx,
  output logic            resultValid
);

  logic busy;

  always_comb begin
    str.start = sampleValid && !busy;
    str.step  = busy;
    str.msb   = busy && (bitIdx == CNTW'(PW - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      bitIdx      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= str.msb;
      if (str.start) begin
        busy   <= 1'b1;
        bitIdx <= '0;
      end else if (busy) begin
        if (str.msb) begin
          busy   <= 1'b0;
          bitIdx <= '0;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R4
  msb_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.msb |=> (!busy && resultValid));

  // R4
  count_progress_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !str.msb) |=> (busy && bitIdx == $past(bitIdx) + 1'b1));

  // R9
  accept_in_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && sampleValid) |-> str.start);

endmodule

// File: rtl/symDaPath.sv
// Datapath: sample history, serial pair pre-adders, partial-sum tables,
// table adder and right-shifting accumulator.
module symDaPath import symDaPkg::*; #(
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int NTAPS = 16,
  parameter int TABIN = 4,
  parameter logic [NTAPS/2*CW-1:0] COEFS = '0,
  localparam int NPAIR = NTAPS / 2,
  localparam int NTAB  = NPAIR / TABIN,
  localparam int PW    = DW + 1,
  localparam int CNTW  = $clog2(PW),
  localparam int SELW  = $clog2(DW),
  localparam int TW    = CW + $clog2(TABIN),
  localparam int PARW  = TW + $clog2(NTAB) + 1,
  localparam int OW    = PARW + PW
) (
  input  logic            clk,
  input  logic            rstN,
  input  daStrobes_t      str,
  input  logic [CNTW-1:0] bitIdx,
  input  logic [DW-1:0]   sampleIn,
  output logic [OW-1:0]   result
);

  // Sample history, newest at index 0.
  logic [DW-1:0] taps [NTAPS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
    end else if (str.start) begin
      taps[0] <= sampleIn;
      for (int k = 1; k < NTAPS; k++) taps[k] <= taps[k-1];
    end
  end

  // Bit position seen by the pre-adders; the extra step repeats the sign.
  logic [SELW-1:0] sel;
  always_comb begin
    if (int'(bitIdx) >= DW) sel = SELW'(DW - 1);
    else                    sel = bitIdx[SELW-1:0];
  end

  // Serial pre-adders on mirrored pairs.
  logic [NPAIR-1:0] carry;
  logic [NPAIR-1:0] sumBit;

  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    logic aBit, bBit;
    assign aBit      = taps[j][sel];
    assign bBit      = taps[NTAPS-1-j][sel];
    assign sumBit[j] = aBit ^ bBit ^ carry[j];

    always_ff @(posedge clk) begin
      if (!rstN)          carry[j] <= 1'b0;
      else if (str.start) carry[j] <= 1'b0;
      else if (str.step)  carry[j] <= (aBit & bBit) | (carry[j] & (aBit ^ bBit));
    end
  end

  // Partial-sum tables, four weights each.
  logic signed [TW-1:0] tabOut [NTAB];

  for (genvar g = 0; g < NTAB; g++) begin : g_tab
    symDaTable #(
      .CW     (CW),
      .TABIN  (TABIN),
      .WEIGHTS(COEFS[g*TABIN*CW +: TABIN*CW])
    ) table_i (
      .addr (sumBit[g*TABIN +: TABIN]),
      .value(tabOut[g])
    );
  end

  logic signed [PARW-1:0] partial;
  always_comb begin
    partial = '0;
    for (int g = 0; g < NTAB; g++)
      partial = partial + {{(PARW-TW){tabOut[g][TW-1]}}, tabOut[g]};
  end

  // Shift accumulator: the high part shifts right, the low bits retire.
  logic signed [PARW-1:0] hi, addend, sumT, hiNext;
  logic [PW-2:0]          lo;
  logic [PW-1:0]          loNext;

  always_comb begin
    addend = str.msb ? -partial : partial;
    sumT   = hi + addend;
    hiNext = sumT >>> 1;
    loNext = {sumT[0], lo};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hi     <= '0;
      lo     <= '0;
      result <= '0;
    end else begin
      if (str.start) begin
        hi <= '0;
        lo <= '0;
      end else if (str.step) begin
        hi <= hiNext;
        lo <= loNext[PW-1:1];
      end
      if (str.step && str.msb) result <= {hiNext, loNext};
    end
  end

  // R5
  newest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.start |=> $stable(taps[0]));

  // R5
  oldest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.start |=> $stable(taps[NTAPS-1]));

  // R8
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.start |=> (carry == '0));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(str.step && str.msb) |=> $stable(result));

endmodule

// File: rtl/symDaFir.sv
module symDaFir import symDaPkg::*; #(
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int NTAPS = 16,
  parameter int TABIN = 4,
  parameter logic [NTAPS/2*CW-1:0] COEFS = 64'hFF11_9C40_E305_7F80,
  localparam int PW   = DW + 1,
  localparam int CNTW = $clog2(PW),
  localparam int TW   = CW + $clog2(TABIN),
  localparam int PARW = TW + $clog2(NTAPS / 2 / TABIN) + 1,
  localparam int OW   = PARW + PW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic [DW-1:0] sampleIn,
  output logic [OW-1:0] result,
  output logic          resultValid
);

  daStrobes_t      strobes;
  logic [CNTW-1:0] bitIdx;

  symDaCtrl #(.DW(DW)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .str        (strobes),
    .bitIdx     (bitIdx),
    .resultValid(resultValid)
  );

  symDaPath #(
    .DW(DW), .CW(CW), .NTAPS(NTAPS), .TABIN(TABIN), .COEFS(COEFS)
  ) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .str     (strobes),
    .bitIdx  (bitIdx),
    .sampleIn(sampleIn),
    .result  (result)
  );

  // R4
  valid_after_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(strobes.msb));

endmodule

// File: tb/symDaFir_tb_top.sv
module symDaFir_tb_top;

  localparam int DW = 8;
  localparam int NTAPS = 16;
  localparam int OW = 21;
  localparam logic [63:0] COEFS = 64'hFF11_9C40_E305_7F80;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic [OW-1:0] result;
  logic          resultValid;

  symDaFir #(.COEFS(COEFS)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .result(result), .resultValid(resultValid)
  );

  always #5 clk = ~clk;

  int     nChecks = 0;
  int     nFail = 0;
  int     cycles = 0;
  bit     checking = 0;
  string  curTag = "R2";

  // Reference model state.
  int     hist [NTAPS];
  int     mCnt = 0;
  bit     expValid = 0;
  longint expResult = 0;
  longint lastOut = 0;
  longint imp [NTAPS];

  function automatic int coefOf(input int j);
    logic [7:0] b;
    b = COEFS[j*8 +: 8];
    return int'($signed(b));
  endfunction

  function automatic longint conv();
    longint s;
    s = 0;
    for (int k = 0; k < NTAPS; k++) begin
      int j;
      j = (k < NTAPS - 1 - k) ? k : NTAPS - 1 - k;
      s += longint'(coefOf(j)) * longint'(hist[k]);
    end
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NTAPS; k++) hist[k] = 0;
      mCnt = 0; expValid = 0; expResult = 0;
    end else begin
      expValid = 0;
      if (mCnt == 0 && sampleValid) begin
        for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'($signed(sampleIn));
        mCnt = 9;
      end else if (mCnt > 0) begin
        mCnt--;
        if (mCnt == 0) begin
          expValid = 1;
          expResult = conv();
        end
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (checking) begin
      longint act;
      act = longint'($signed(result));
      nChecks++;
      if (resultValid !== expValid) begin
        nFail++;
        $display("FAIL R4: resultValid %0b expected %0b", resultValid, expValid);
      end
      nChecks++;
      if (act != expResult) begin
        nFail++;
        $display("FAIL %s: result %0d expected %0d", expValid ? curTag : "R6", act, expResult);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
      finishRun();
    end
  end

  task automatic oneSample(input logic [7:0] v, input int gap);
    @(negedge clk); sampleValid = 1'b1; sampleIn = v;
    @(negedge clk); sampleValid = 1'b0; sampleIn = 8'($urandom);
    repeat (9) @(negedge clk);
    lastOut = longint'($signed(result));
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    nChecks++;
    if (resultValid !== 1'b0) begin
      nFail++; $display("FAIL R1: resultValid %0b expected 0", resultValid);
    end
    nChecks++;
    if (result !== '0) begin
      nFail++; $display("FAIL R1: result %0d expected 0", $signed(result));
    end
    rstN = 1'b1;
    checking = 1;

    // R1: first output sees zero history
    curTag = "R1";
    oneSample(8'd37, 0);

    // R3: impulse response and its mirror symmetry
    curTag = "R3";
    for (int k = 0; k < NTAPS; k++) oneSample(8'd0, 0);
    oneSample(8'd1, 0);
    imp[0] = lastOut;
    for (int k = 1; k < NTAPS; k++) begin
      oneSample(8'd0, 0);
      imp[k] = lastOut;
    end
    for (int k = 0; k < NTAPS / 2; k++) begin
      nChecks++;
      if (imp[k] != imp[NTAPS-1-k]) begin
        nFail++;
        $display("FAIL R3: tap %0d response %0d expected %0d", NTAPS-1-k, imp[NTAPS-1-k], imp[k]);
      end
      nChecks++;
      if (imp[k] != longint'(coefOf(k))) begin
        nFail++;
        $display("FAIL R3: tap %0d response %0d expected %0d", k, imp[k], coefOf(k));
      end
    end

    // R2: random samples with random idle gaps
    curTag = "R2";
    for (int i = 0; i < 150; i++) oneSample(8'($urandom), int'($urandom_range(0, 3)));

    // R7: full-scale runs
    curTag = "R7";
    for (int i = 0; i < 18; i++) oneSample(8'h80, 0);
    for (int i = 0; i < 18; i++) oneSample(8'h7F, 0);

    // R8: alternating extremes stress carry clearing
    curTag = "R8";
    for (int i = 0; i < 24; i++) oneSample((i % 2 == 0) ? 8'h80 : 8'h7F, 0);
    for (int i = 0; i < 24; i++) oneSample((i % 2 == 0) ? 8'hFF : 8'h01, 0);

    // R5 R9: valid held high, data changing every cycle
    curTag = "R5 R9";
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleIn = 8'($urandom);
    end
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (12) @(negedge clk);

    finishRun();
  end

endmodule